// File: doc/BRIEF.md
# Single-Cycle 64-bit Subset Processor

This block is a single-cycle sequential processor core for a compact 64-bit teaching instruction set. In every clock cycle it presents its program counter on the fetch port and receives up to ten instruction bytes, little-endian, from an external byte-addressed memory model. It decodes the opcode and function nibbles and reads two operands from a fifteen-entry register file. It then forms an ALU result or an effective address, may issue one 8-byte store, writes back at most one register and chooses the next program counter. The register write, the flag update, the store and the program counter update all take effect at the rising clock edge that closes the instruction's cycle.

The supported work covers halt, nop, immediate load into a register, register copy with its conditional variants, four arithmetic/logic operations with sign and zero flags, an unconditional jump, and a register-to-memory store. Every memory address counts as valid. A status output reports normal running, halt or an illegal opcode. Once the status leaves normal running, the processor freezes its architectural state.

Top module: `seqp_core`

## Requirements
- R1: `status` is 2'd1 when the fetched opcode nibble (byte 0 bits [7:4]) is 0x0, 2'd2 when it is above 0xB, and 2'd0 for opcodes 0x1 through 0xB.
- R2: While `status` is not 2'd0, `fetch_addr` stays unchanged from cycle to cycle and `store_en` stays low, so registers and memory do not change.
- R3: Opcode 0x3 is 10 bytes long. It writes the 64-bit immediate in bits [79:16] into the register named by bits [11:8], and the next fetch address is the current one plus 10.
- R4: Opcode 0x2 with function 0 is 2 bytes long. It copies the register named by bits [15:12] into the register named by bits [11:8], and the next fetch address is the current one plus 2.
- R5: Opcode 0x2 with function 1..6 is a conditional copy. The conditions are 1: SF or ZF, 2: SF, 3: ZF, 4: not ZF, 5: not SF, 6: neither SF nor ZF, and functions 7..F never copy. When the condition fails, the destination is replaced by "no register" (index 0xF) and nothing is written.
- R6: Opcode 0x6 is 2 bytes long. It writes rB op rA to rB, with function 0 add, 1 subtract (rB minus rA), 2 AND and 3 XOR. It sets SF to bit 63 of the result and ZF to result-equals-zero. No other opcode changes the flags.
- R7: Opcode 0x4 is 10 bytes long. In its cycle it raises `store_en` with `store_addr` = R[rB] + immediate[79:16] and `store_data` = R[rA], written little-endian, so storing 8 at 160 plus 2 puts byte 0x08 at address 0xA2.
- R8: Opcode 0x7 loads the next fetch address with the 64-bit immediate held in bits [71:8].
- R9: Opcode 0x1 changes nothing but the fetch address, which advances by 1. The other in-range opcodes without an action here (0x5, 0x8..0xB) behave the same way.
- R10: Reset clears the fetch address and all registers to 0 and sets the flags to SF=0, ZF=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | output | 64 | Address of the instruction being executed (program counter) |
| fetch_bytes | input | 80 | Ten instruction bytes starting at `fetch_addr`, byte k in bits [8k+7:8k] |
| store_en | output | 1 | Store request, committed at the next rising edge |
| store_addr | output | 64 | Byte address of the 8-byte store |
| store_data | output | 64 | Little-endian store value |
| status | output | 2 | 0 running, 1 halted, 2 illegal opcode |

## Verification
The embedded properties assume that `fetch_bytes` holds the bytes at `fetch_addr` and stays stable between the moment the address changes and the next rising edge. They also assume that a halt or illegal opcode is refetched for as long as the address holds. The bench meets both assumptions: it drives each instruction only after checking the new fetch address at the falling edge, and it keeps a halt or an illegal opcode on the port for the whole freeze window. The instruction stream is chosen so that every flag combination used by a conditional copy arises from an earlier ALU operation, and every register value is read back through a later store.

// File: rtl/seqp_pkg.sv
package seqp_pkg;
   localparam logic [3:0] OP_HALT  = 4'h0;
   localparam logic [3:0] OP_NOP   = 4'h1;
   localparam logic [3:0] OP_RRMOV = 4'h2;
   localparam logic [3:0] OP_IRMOV = 4'h3;
   localparam logic [3:0] OP_RMMOV = 4'h4;
   localparam logic [3:0] OP_ALU   = 4'h6;
   localparam logic [3:0] OP_JUMP  = 4'h7;
   localparam logic [3:0] OP_LAST  = 4'hB;

   localparam logic [3:0] FN_ADD = 4'h0;
   localparam logic [3:0] FN_SUB = 4'h1;
   localparam logic [3:0] FN_AND = 4'h2;
   localparam logic [3:0] FN_XOR = 4'h3;

   localparam logic [3:0] REG_NONE = 4'hF;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_HALT  = 2'd1,
      ST_BADOP = 2'd2
   } stat_e;

   typedef struct packed {
      logic sign;
      logic zero;
   } flags_t;
endpackage

// File: rtl/seqp_decode.sv
module seqp_decode
   import seqp_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W+15:0] insn,
   input  logic [DATA_W-1:0]  pc,
   output logic [3:0]         icode,
   output logic [3:0]         ifun,
   output logic [3:0]         ra,
   output logic [3:0]         rb,
   output logic [DATA_W-1:0]  valc,
   output logic [DATA_W-1:0]  pc_seq,
   output stat_e              stat
);
   localparam int IMM_B = DATA_W / 8;
   localparam logic [DATA_W-1:0] LEN_1    = DATA_W'(1);
   localparam logic [DATA_W-1:0] LEN_2    = DATA_W'(2);
   localparam logic [DATA_W-1:0] LEN_JUMP = DATA_W'(1 + IMM_B);
   localparam logic [DATA_W-1:0] LEN_LONG = DATA_W'(2 + IMM_B);

   logic [DATA_W-1:0] len;

   assign icode = insn[7:4];
   assign ifun  = insn[3:0];
   assign ra    = insn[15:12];
   assign rb    = insn[11:8];

   // jump carries its target right after the opcode byte
   assign valc = (icode == OP_JUMP) ? insn[DATA_W+7:8] : insn[DATA_W+15:16];

   always_comb begin
      unique case (icode)
         OP_RRMOV, OP_ALU:   len = LEN_2;
         OP_IRMOV, OP_RMMOV: len = LEN_LONG;
         OP_JUMP:            len = LEN_JUMP;
         default:            len = LEN_1;
      endcase
   end

   assign pc_seq = pc + len;

   always_comb begin
      if (icode == OP_HALT)     stat = ST_HALT;
      else if (icode > OP_LAST) stat = ST_BADOP;
      else                      stat = ST_RUN;
   end
endmodule

// File: rtl/seqp_regfile.sv
module seqp_regfile #(
   parameter int DATA_W   = 64,
   parameter int NUM_REGS = 15,
   parameter int IDX_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_a_idx,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int IDX_LIMIT = (1 << IDX_W) - 1;

   generate
      if (NUM_REGS > IDX_LIMIT || NUM_REGS < 1) begin : g_bad_depth
         $error("seqp_regfile: NUM_REGS must leave the all-ones index free");
      end
   endgenerate

   logic [DATA_W-1:0] regs [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NUM_REGS; i++)
            if (wr_idx == IDX_W'(i)) regs[i] <= wr_data;
      end
   end

   always_comb begin
      rd_a = '0;
      rd_b = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_a_idx == IDX_W'(i)) rd_a = regs[i];
         if (rd_b_idx == IDX_W'(i)) rd_b = regs[i];
      end
   end

   // R5: a cancelled move or a "none" destination never reaches the array
   a_r5_no_write_to_none: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NUM_REGS));
endmodule

// File: rtl/seqp_alu.sv
module seqp_alu
   import seqp_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [3:0]        ifun,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  flags_t            flags,
   output logic [DATA_W-1:0] result,
   output flags_t            flags_nxt,
   output logic              cond_ok
);
   always_comb begin
      unique case (ifun)
         FN_SUB:  result = opb - opa;
         FN_AND:  result = opb & opa;
         FN_XOR:  result = opb ^ opa;
         default: result = opb + opa;
      endcase
   end

   assign flags_nxt.sign = result[DATA_W-1];
   assign flags_nxt.zero = (result == '0);

   always_comb begin
      unique case (ifun)
         4'h0:    cond_ok = 1'b1;
         4'h1:    cond_ok = flags.sign | flags.zero;
         4'h2:    cond_ok = flags.sign;
         4'h3:    cond_ok = flags.zero;
         4'h4:    cond_ok = ~flags.zero;
         4'h5:    cond_ok = ~flags.sign;
         4'h6:    cond_ok = ~flags.sign & ~flags.zero;
         default: cond_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/seqp_core.sv
module seqp_core
   import seqp_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int NUM_REGS = 15,
   parameter int IDX_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [DATA_W-1:0] fetch_addr,
   input  logic [DATA_W+15:0] fetch_bytes,
   output logic              store_en,
   output logic [DATA_W-1:0] store_addr,
   output logic [DATA_W-1:0] store_data,
   output logic [1:0]        status
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
         $error("seqp_core: DATA_W must be a whole number of bytes, at least 16");
      end
      if (IDX_W != 4) begin : g_bad_idx
         $error("seqp_core: register fields are nibbles, IDX_W must be 4");
      end
   endgenerate

   logic [DATA_W-1:0] pc_q;
   logic [3:0]        icode, ifun, ra, rb;
   logic [DATA_W-1:0] valc, pc_seq, pc_nxt;
   stat_e             stat;
   logic [DATA_W-1:0] rd_a, rd_b, alu_res, wr_data;
   flags_t            flags_q, flags_nxt;
   logic              cond_ok, running, wr_en;
   logic [3:0]        dst;

   seqp_decode #(.DATA_W(DATA_W)) u_decode (
      .insn(fetch_bytes), .pc(pc_q), .icode(icode), .ifun(ifun),
      .ra(ra), .rb(rb), .valc(valc), .pc_seq(pc_seq), .stat(stat)
   );

   seqp_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .rd_a_idx(ra), .rd_b_idx(rb),
      .rd_a(rd_a), .rd_b(rd_b), .wr_en(wr_en), .wr_idx(dst), .wr_data(wr_data)
   );

   seqp_alu #(.DATA_W(DATA_W)) u_alu (
      .ifun(ifun), .opa(rd_a), .opb(rd_b), .flags(flags_q),
      .result(alu_res), .flags_nxt(flags_nxt), .cond_ok(cond_ok)
   );

   assign running = (stat == ST_RUN);

   // failed condition wins over the ordinary copy destination
   always_comb begin
      if (icode == OP_RRMOV && !cond_ok)                       dst = REG_NONE;
      else if (icode == OP_RRMOV || icode == OP_IRMOV || icode == OP_ALU) dst = rb;
      else                                                     dst = REG_NONE;
   end

   always_comb begin
      unique case (icode)
         OP_IRMOV: wr_data = valc;
         OP_RRMOV: wr_data = rd_a;
         default:  wr_data = alu_res;
      endcase
   end

   assign wr_en  = running && (dst != REG_NONE);
   assign pc_nxt = (icode == OP_JUMP) ? valc : pc_seq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         flags_q <= '{sign: 1'b0, zero: 1'b1};
      end else if (running) begin
         pc_q <= pc_nxt;
         if (icode == OP_ALU) flags_q <= flags_nxt;
      end
   end

   assign fetch_addr = pc_q;
   assign store_en   = running && (icode == OP_RMMOV);
   assign store_addr = rd_b + valc;
   assign store_data = rd_a;
   assign status     = stat;

   // R2: a stopped machine keeps its fetch address
   a_r2_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 2'd0) |=> (fetch_addr == $past(fetch_addr)));

   // R8: jump lands on its immediate
   a_r8_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
      (running && icode == OP_JUMP) |=> (fetch_addr == $past(valc)));

   // R9: nop steps by one byte
   a_r9_nop_step: assert property (@(posedge clk) disable iff (!rst_n)
      (running && icode == OP_NOP) |=> (fetch_addr == $past(fetch_addr) + ONE));

   // R6: flags move only on an executed ALU operation
   a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(running && icode == OP_ALU) |=> (flags_q == $past(flags_q)));
endmodule

// File: tb/test_seqp_core.sv
module test_seqp_core;
   typedef struct packed {
      logic [3:0]  op;
      logic [3:0]  fn;
      logic [3:0]  ra;
      logic [3:0]  rb;
      logic [63:0] imm;
      logic [15:0] pc;
      logic        st;
      logic [15:0] saddr;
      logic [63:0] sdata;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 29;
   // op fn ra rb imm | expected pc, store, address, data | requirement
   localparam vec_t VECS [NV] = '{
      '{4'h3,4'h0,4'hF,4'h0,64'h162E,16'd0,  1'b0,16'h0,   64'h0,    4'd3},  // R3 rax
      '{4'h3,4'h0,4'hF,4'h1,64'h22,  16'd10, 1'b0,16'h0,   64'h0,    4'd3},  // R3 rcx
      '{4'h2,4'h0,4'h0,4'h2,64'h0,   16'd20, 1'b0,16'h0,   64'h0,    4'd4},  // R4 rax->rdx
      '{4'h2,4'h0,4'h1,4'h0,64'h0,   16'd22, 1'b0,16'h0,   64'h0,    4'd4},  // R4 rcx->rax
      '{4'h4,4'h0,4'h2,4'h0,64'h0,   16'd24, 1'b1,16'h22,  64'h162E, 4'd4},  // R4 rdx kept
      '{4'h4,4'h0,4'h0,4'h1,64'h100, 16'd34, 1'b1,16'h122, 64'h22,   4'd7},  // R7 disp
      '{4'h3,4'h0,4'hF,4'h0,64'h2,   16'd44, 1'b0,16'h0,   64'h0,    4'd3},
      '{4'h3,4'h0,4'hF,4'h3,64'h8,   16'd54, 1'b0,16'h0,   64'h0,    4'd3},
      '{4'h4,4'h0,4'h3,4'h0,64'hA0,  16'd64, 1'b1,16'hA2,  64'h8,    4'd7},  // R7 byte 0xA2
      '{4'h6,4'h0,4'h0,4'h3,64'h0,   16'd74, 1'b0,16'h0,   64'h0,    4'd6},  // add rbx=A
      '{4'h6,4'h1,4'h3,4'h0,64'h0,   16'd76, 1'b0,16'h0,   64'h0,    4'd6},  // sub rax=-8
      '{4'h2,4'h2,4'h1,4'h6,64'h0,   16'd78, 1'b0,16'h0,   64'h0,    4'd5},  // cmovl taken
      '{4'h2,4'h3,4'h1,4'h7,64'h0,   16'd80, 1'b0,16'h0,   64'h0,    4'd5},  // cmove skipped
      '{4'h6,4'h2,4'h0,4'h2,64'h0,   16'd82, 1'b0,16'h0,   64'h0,    4'd6},  // and rdx=1628
      '{4'h6,4'h3,4'h1,4'h1,64'h0,   16'd84, 1'b0,16'h0,   64'h0,    4'd6},  // xor rcx=0
      '{4'h2,4'h1,4'h2,4'h5,64'h0,   16'd86, 1'b0,16'h0,   64'h0,    4'd5},  // cmovle taken
      '{4'h2,4'h4,4'h2,4'h7,64'h0,   16'd88, 1'b0,16'h0,   64'h0,    4'd5},  // cmovne skipped
      '{4'h4,4'h0,4'h0,4'h6,64'h0,   16'd90, 1'b1,16'h22,  64'hFFFF_FFFF_FFFF_FFF8, 4'd6},
      '{4'h4,4'h0,4'h7,4'h5,64'h10,  16'd100,1'b1,16'h1638,64'h0,    4'd5},
      '{4'h4,4'h0,4'h3,4'h1,64'h0,   16'd110,1'b1,16'h0,   64'hA,    4'd6},
      '{4'h1,4'h0,4'hF,4'hF,64'h0,   16'd120,1'b0,16'h0,   64'h0,    4'd9},  // R9 nop
      '{4'h7,4'h0,4'hF,4'hF,64'h200, 16'd121,1'b0,16'h0,   64'h0,    4'd8},  // R8 jump
      '{4'h4,4'h0,4'h2,4'h5,64'h0,   16'd512,1'b1,16'h1628,64'h1628, 4'd8},
      '{4'h2,4'h6,4'h2,4'h4,64'h0,   16'd522,1'b0,16'h0,   64'h0,    4'd5},  // cmovg skipped
      '{4'h2,4'h5,4'h2,4'h8,64'h0,   16'd524,1'b0,16'h0,   64'h0,    4'd5},  // cmovge taken
      '{4'h4,4'h0,4'h4,4'h8,64'h0,   16'd526,1'b1,16'h1628,64'h0,    4'd5},
      '{4'h4,4'h0,4'h8,4'h5,64'h8,   16'd536,1'b1,16'h1630,64'h1628, 4'd5},
      '{4'h5,4'h0,4'hF,4'hF,64'h0,   16'd546,1'b0,16'h0,   64'h0,    4'd9},  // R9 op 5
      '{4'hB,4'h0,4'hF,4'hF,64'h0,   16'd547,1'b0,16'h0,   64'h0,    4'd1}   // R1 op B runs
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] fetch_addr;
   logic [79:0] fetch_bytes = '0;
   logic        store_en;
   logic [63:0] store_addr, store_data;
   logic [1:0]  status;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   seqp_core i_seqp_core (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_bytes(fetch_bytes),
      .store_en(store_en), .store_addr(store_addr), .store_data(store_data), .status(status)
   );

   function automatic logic [79:0] enc(input logic [3:0] op, fn, ra, rb,
                                       input logic [63:0] imm);
      logic [79:0] b = '0;
      b[7:0] = {op, fn};
      if (op == 4'h7) b[71:8] = imm;
      else begin
         b[15:8]  = {ra, rb};
         b[79:16] = imm;
      end
      return b;
   endfunction

   task automatic chk(input int req, input string what, input logic [63:0] act, exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // called just after a falling edge; returns at the next falling edge
   task automatic run_vec(input vec_t v);
      chk(int'(v.req), "fetch address", fetch_addr, 64'(v.pc));
      fetch_bytes = enc(v.op, v.fn, v.ra, v.rb, v.imm);
      #1;
      chk(1, "status", 64'(status), 64'd0);
      chk(int'(v.req), "store_en", 64'(store_en), 64'(v.st));
      if (v.st) begin
         chk(int'(v.req), "store_addr", store_addr, 64'(v.saddr));
         chk(int'(v.req), "store_data", store_data, v.sdata);
      end
      @(negedge clk);
   endtask

   initial begin
      fetch_bytes = enc(4'h1, 4'h0, 4'hF, 4'hF, 64'h0);
      repeat (2) @(negedge clk);
      chk(10, "reset fetch address", fetch_addr, 64'h0);          // R10
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R1/R2: halt freezes the machine
      chk(2, "fetch address before halt", fetch_addr, 64'd548);
      fetch_bytes = enc(4'h0, 4'h0, 4'h4, 4'h0, 64'h0);
      #1;
      chk(1, "halt status", 64'(status), 64'd1);
      chk(2, "store_en while halted", 64'(store_en), 64'd0);
      repeat (3) @(negedge clk);
      chk(2, "fetch address held by halt", fetch_addr, 64'd548);

      // R10: reset again, flags come up with ZF set
      rst_n = 1'b0;
      fetch_bytes = enc(4'h1, 4'h0, 4'hF, 4'hF, 64'h0);
      #1;
      chk(10, "fetch address in reset", fetch_addr, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      run_vec('{4'h3,4'h0,4'hF,4'h0,64'h7,16'd0, 1'b0,16'h0,64'h0,4'd10});
      run_vec('{4'h2,4'h3,4'h0,4'h3,64'h0,16'd10,1'b0,16'h0,64'h0,4'd10}); // cmove on reset ZF
      run_vec('{4'h4,4'h0,4'h3,4'h1,64'h0,16'd12,1'b1,16'h0,64'h7,4'd10}); // r10_ rcx reset 0

      // R1/R2: illegal opcode freezes too
      fetch_bytes = enc(4'hC, 4'h0, 4'h0, 4'h0, 64'h0);
      #1;
      chk(1, "opcode C status", 64'(status), 64'd2);
      chk(2, "store_en on illegal opcode", 64'(store_en), 64'd0);
      repeat (2) @(negedge clk);
      chk(2, "fetch address held by illegal opcode", fetch_addr, 64'd22);
      fetch_bytes = enc(4'hF, 4'h0, 4'h0, 4'h0, 64'h0);
      #1;
      chk(1, "opcode F status", 64'(status), 64'd2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule